// File: doc/BRIEF.md
# ARINC 429 Receiver Bit-Timing Validator

This block sits behind a line receiver's level detectors. It takes three decoded line-state indications (one, zero, null), samples them once per clock in high-speed mode or once every eight clocks in low-speed mode, and keeps the most recent ten samples of each in its own shift register. From these windows it decides when a data bit is valid, checks the spacing between bits, and shifts accepted bits into a 32-bit word. When the 32nd bit is accepted, it presents the word and pulses an end-of-sequence strobe.

A timing violation aborts the word in progress and pulses an error strobe. After either outcome, the block re-arms only when a word-gap timer has seen enough line-null time. When frequency discrimination is switched off, bits may arrive at any spacing, but the pulse-shape rule and the word-gap rule still apply.

Top module: `a429_rx_bit_timing`

## Requirements
- R1: During and after reset, word_o is 0 and eos_o and err_o are low. A word that starts before a full word gap has been seen after reset is dropped, with no eos_o and no err_o.
- R2: With low_speed_i low, the lines are sampled on every clock. With low_speed_i high, they are sampled once every 8 clocks, so a bit pattern held 8 clocks per sample is received like a high-speed one. A pattern changing every clock in low-speed mode produces no word.
- R3: A data bit is accepted on the third consecutive null sample that immediately follows at least three consecutive one samples (bit value 1) or zero samples (bit value 0). A null run of three that follows a shorter pulse is a pulse-width violation and raises err_o.
- R4: With freq_disc_en_i high, an accepted bit must lie 8 to 12 samples after the previous accepted bit. A bit at a spacing of 7 or less aborts the word with err_o.
- R5: With freq_disc_en_i low, bit spacing is not checked. A word of 32 valid bits at 20 samples per bit is received.
- R6: The first bit received is placed in word_o[0] and the 32nd bit in word_o[31]. word_o changes only in the cycle in which eos_o is high.
- R7: eos_o is a single-clock pulse, issued once per word of 32 accepted bits.
- R8: After eos_o or err_o, reception resumes only after three consecutive word-gap checks pass. A check is made every 10 samples. It passes when the newest three and the oldest three of the last ten null samples are all null. A word arriving earlier is dropped without err_o.
- R9: err_o is a single-clock pulse. It never coincides with eos_o, and it clears the bit count so that no partial word completes.
- R10: With freq_disc_en_i high, if no bit is accepted within 12 samples of the previous one, err_o is raised at the 13th sample without waiting for the late bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_one_i | input | 1 | Line detector reports a one level |
| line_zero_i | input | 1 | Line detector reports a zero level |
| line_null_i | input | 1 | Line detector reports a null level |
| low_speed_i | input | 1 | Sample once every 8 clocks instead of every clock |
| freq_disc_en_i | input | 1 | Enable the bit-spacing checks |
| word_o | output | 32 | Last received word, first bit in bit 0 |
| eos_o | output | 1 | One-cycle pulse when a 32-bit word completes |
| err_o | output | 1 | One-cycle pulse when a timing violation aborts reception |

## Verification
The embedded assertions watch every cycle for these properties:
- end-of-sequence and error are each one-cycle pulses and never occur together;
- word_o holds steady except in the end-of-sequence cycle;
- a short or late bit spacing is always followed by an error;
- the re-arm point of the word-gap timer is always preceded by a passing null check;
- low-speed sample ticks never fall on two consecutive clocks.

Only the bench scenarios can show the behaviour at word level:
- the bit order in the assembled word;
- acceptance at the 8- and 12-sample spacing limits and rejection at 7 and 13;
- the dropping of words that arrive before the word gap, including the first word after reset;
- the effect of the low-speed divider and of disabling discrimination.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  typedef enum logic [1:0] {
    ST_GAP  = 2'd0,
    ST_IDLE = 2'd1,
    ST_RX   = 2'd2
  } rx_state_e;

  localparam int WORD_BITS_D   = 32;
  localparam int SR_LEN_D      = 10;
  localparam int WIN_D         = 3;
  localparam int LS_DIV_D      = 8;
  localparam int MIN_SP_D      = 8;
  localparam int MAX_SP_D      = 12;
  localparam int GAP_SAMPLES_D = 10;
  localparam int GAP_NULLS_D   = 3;
endpackage

// File: rtl/a429_sample_tick.sv
module a429_sample_tick #(
  parameter int LS_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  output logic tick_o
);
  localparam int DW = (LS_DIV > 1) ? $clog2(LS_DIV) : 1;

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!low_speed_i) cnt_q <= '0;
    else if (cnt_q == DW'(LS_DIV - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !low_speed_i || (cnt_q == DW'(LS_DIV - 1));

  // R2: in low-speed mode ticks are spread out
  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_speed_i && tick_o) |=> (!tick_o || !low_speed_i));
endmodule

// File: rtl/a429_line_sampler.sv
module a429_line_sampler #(
  parameter int SR_LEN = 10,
  parameter int WIN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic one_i,
  input  logic zero_i,
  input  logic null_i,
  output logic fresh_o,
  output logic bit_ev_o,
  output logic bit_val_o,
  output logic bad_o,
  output logic gap_null_o
);
  logic [SR_LEN-1:0] one_sr_q, zero_sr_q, null_sr_q;
  logic              fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      one_sr_q  <= '0;
      zero_sr_q <= '0;
      null_sr_q <= '0;
      fresh_q   <= 1'b0;
    end else begin
      fresh_q <= tick_i;
      if (tick_i) begin
        one_sr_q  <= {one_sr_q[SR_LEN-2:0],  one_i};
        zero_sr_q <= {zero_sr_q[SR_LEN-2:0], zero_i};
        null_sr_q <= {null_sr_q[SR_LEN-2:0], null_i};
      end
    end
  end

  logic null_new, null_start, one_run, zero_run;

  // newest WIN samples null, sample before them not null
  assign null_new   = &null_sr_q[WIN-1:0];
  assign null_start = null_new && !null_sr_q[WIN];
  assign one_run    = &one_sr_q[2*WIN-1:WIN];
  assign zero_run   = &zero_sr_q[2*WIN-1:WIN];

  assign fresh_o    = fresh_q;
  assign bit_ev_o   = fresh_q && null_start && (one_run || zero_run);
  assign bit_val_o  = one_run;
  assign bad_o      = fresh_q && null_start && !(one_run || zero_run);
  assign gap_null_o = null_new && (&null_sr_q[SR_LEN-1 -: WIN]);
endmodule

// File: rtl/a429_word_gap.sv
module a429_word_gap #(
  parameter int GAP_SAMPLES = 10,
  parameter int GAP_NULLS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fresh_i,
  input  logic gap_null_i,
  output logic done_o
);
  localparam int DVW = $clog2(GAP_SAMPLES);
  localparam int CW  = $clog2(GAP_NULLS + 1);

  logic [DVW-1:0] div_q;
  logic [CW-1:0]  cnt_q;

  assign done_o = (cnt_q == CW'(GAP_NULLS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (fresh_i) begin
      if (div_q == DVW'(GAP_SAMPLES - 1)) begin
        div_q <= '0;
        if (!gap_null_i) cnt_q <= '0;
        else if (!done_o) cnt_q <= cnt_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R8: re-arm only follows a passing null check
  a_r8_gap_needs_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(gap_null_i));
endmodule

// File: rtl/a429_rx_bit_timing.sv
module a429_rx_bit_timing
  import a429_rx_pkg::*;
#(
  parameter int WORD_BITS   = WORD_BITS_D,
  parameter int SR_LEN      = SR_LEN_D,
  parameter int WIN         = WIN_D,
  parameter int LS_DIV      = LS_DIV_D,
  parameter int MIN_SP      = MIN_SP_D,
  parameter int MAX_SP      = MAX_SP_D,
  parameter int GAP_SAMPLES = GAP_SAMPLES_D,
  parameter int GAP_NULLS   = GAP_NULLS_D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_one_i,
  input  logic                 line_zero_i,
  input  logic                 line_null_i,
  input  logic                 low_speed_i,
  input  logic                 freq_disc_en_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 eos_o,
  output logic                 err_o
);
  localparam int BCW = $clog2(WORD_BITS);
  localparam int SPW = $clog2(MAX_SP + 2);

  logic tick, fresh, bit_ev, bit_val, bad, gap_null, gap_done;

  a429_sample_tick #(.LS_DIV(LS_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_speed_i(low_speed_i), .tick_o(tick));

  a429_line_sampler #(.SR_LEN(SR_LEN), .WIN(WIN)) u_sampler (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .one_i(line_one_i), .zero_i(line_zero_i), .null_i(line_null_i),
    .fresh_o(fresh), .bit_ev_o(bit_ev), .bit_val_o(bit_val),
    .bad_o(bad), .gap_null_o(gap_null));

  rx_state_e state_q;

  a429_word_gap #(.GAP_SAMPLES(GAP_SAMPLES), .GAP_NULLS(GAP_NULLS)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(state_q == ST_GAP),
    .fresh_i(fresh), .gap_null_i(gap_null), .done_o(gap_done));

  logic [SPW-1:0]       sp_q;
  logic [BCW-1:0]       bit_cnt_q;
  logic [WORD_BITS-1:0] sh_q, word_q;
  logic                 eos_q, err_q;

  // samples since last accepted bit, minus one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else if (fresh) begin
      if (bit_ev) sp_q <= '0;
      else if (sp_q != '1) sp_q <= sp_q + 1'b1;
    end
  end

  logic sp_ok, sp_late, abort;
  assign sp_ok   = !freq_disc_en_i ||
                   (sp_q >= SPW'(MIN_SP - 1) && sp_q <= SPW'(MAX_SP - 1));
  assign sp_late = freq_disc_en_i && (sp_q >= SPW'(MAX_SP));
  assign abort   = bad || (bit_ev && !sp_ok) || (!bit_ev && sp_late);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_GAP;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      word_q    <= '0;
      eos_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      eos_q <= 1'b0;
      err_q <= 1'b0;
      unique case (state_q)
        ST_GAP: if (gap_done) state_q <= ST_IDLE;
        ST_IDLE: if (fresh) begin
          if (bad) begin
            err_q   <= 1'b1;
            state_q <= ST_GAP;
          end else if (bit_ev) begin
            sh_q      <= {bit_val, sh_q[WORD_BITS-1:1]};
            bit_cnt_q <= BCW'(1);
            state_q   <= ST_RX;
          end
        end
        ST_RX: if (fresh) begin
          if (abort) begin
            err_q     <= 1'b1;
            bit_cnt_q <= '0;
            state_q   <= ST_GAP;
          end else if (bit_ev) begin
            sh_q <= {bit_val, sh_q[WORD_BITS-1:1]};
            if (bit_cnt_q == BCW'(WORD_BITS - 1)) begin
              word_q    <= {bit_val, sh_q[WORD_BITS-1:1]};
              eos_q     <= 1'b1;
              bit_cnt_q <= '0;
              state_q   <= ST_GAP;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_GAP;
      endcase
    end
  end

  assign word_o = word_q;
  assign eos_o  = eos_q;
  assign err_o  = err_q;

  // R7: strobe lasts one clock
  a_r7_eos_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);

  // R9: error and end-of-sequence are exclusive
  a_r9_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eos_o && err_o));

  // R6: word only moves with the strobe
  a_r6_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eos_o |-> $stable(word_o));

  // R4: early bit always aborts
  a_r4_short_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX && bit_ev && freq_disc_en_i && sp_q < SPW'(MIN_SP - 1))
      |=> err_o);

  // R10: missing bit aborts at the window end
  a_r10_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX && fresh && !bit_ev && freq_disc_en_i && sp_q >= SPW'(MAX_SP))
      |=> err_o);
endmodule

// File: tb/a429_rx_bit_timing_bench.sv
module a429_rx_bit_timing_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        one_l = 1'b0, zero_l = 1'b0, null_l = 1'b1;
  logic        low_speed = 1'b0, disc = 1'b1;
  logic [31:0] word;
  logic        eos, err;

  always #10 clk = ~clk;

  a429_rx_bit_timing u_a429_rx_bit_timing (
    .clk_i(clk), .rst_ni(rst_n),
    .line_one_i(one_l), .line_zero_i(zero_l), .line_null_i(null_l),
    .low_speed_i(low_speed), .freq_disc_en_i(disc),
    .word_o(word), .eos_o(eos), .err_o(err));

  int tests = 0, fails = 0;
  int eos_cnt = 0, err_cnt = 0, eos_wide = 0, both_hi = 0;
  logic eos_prev = 1'b0;
  logic [31:0] last_word = '0;

  always @(negedge clk) begin
    if (eos) begin eos_cnt++; last_word = word; end
    if (err) err_cnt++;
    if (eos && eos_prev) eos_wide++;
    if (eos && err) both_hi++;
    eos_prev = eos;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 null, 1 one, 2 zero
  task automatic smp(input int kind, input int div);
    null_l = (kind == 0); one_l = (kind == 1); zero_l = (kind == 2);
    repeat (div) @(negedge clk);
  endtask

  task automatic nulls(input int n, input int div);
    for (int i = 0; i < n; i++) smp(0, div);
  endtask

  task automatic send_word(input logic [31:0] w, input int per, input int hi, input int div);
    for (int b = 0; b < 32; b++) begin
      for (int k = 0; k < hi; k++) smp(w[b] ? 1 : 2, div);
      nulls(per - hi, div);
    end
  endtask

  function automatic bit pred_ok(input int per, input int hi, input bit d);
    return (hi >= 3) && (per - hi >= 3) && (!d || (per >= 8 && per <= 12));
  endfunction

  task automatic run_case(input logic [31:0] w, input int per, input int hi,
                          input bit d, input int div, input string req);
    int e0, r0;
    bit ok;
    disc = d;
    e0 = eos_cnt; r0 = err_cnt;
    send_word(w, per, hi, div);
    nulls(45, div);
    ok = pred_ok(per, hi, d);
    if (ok) begin
      chk(eos_cnt - e0 == 1, {req, " eos count"}, 32'(eos_cnt - e0), 32'd1);
      chk(err_cnt == r0, {req, " no err"}, 32'(err_cnt - r0), 32'd0);
      chk(last_word == w, {req, " word"}, last_word, w);
    end else begin
      chk(eos_cnt == e0, {req, " rejected no eos"}, 32'(eos_cnt - e0), 32'd0);
      chk(err_cnt > r0, {req, " rejected err"}, 32'(err_cnt - r0), 32'd1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int e0, r0, seed_dummy;
    seed_dummy = $urandom(32'd4291);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(word == 0 && !eos && !err, "R1 reset outputs", {word[31:2], eos, err}, 32'd0);
    rst_n = 1'b1;
    // R1 word with no preceding gap dropped
    e0 = eos_cnt; r0 = err_cnt;
    send_word(32'hA5A5_0F0F, 10, 5, 1);
    chk(eos_cnt == e0 && err_cnt == r0, "R1 no word before gap", 32'(eos_cnt - e0 + err_cnt - r0), 32'd0);
    nulls(45, 1);
    // R6 bit order, R7 strobe
    run_case(32'h8000_0001, 10, 5, 1'b1, 1, "R6 R7 nominal");
    run_case(32'h1234_5678, 10, 5, 1'b1, 1, "R6 pattern");
    // R3 pulse width
    run_case(32'hFFFF_0000, 10, 3, 1'b1, 1, "R3 min pulse");
    run_case(32'hFFFF_0000, 10, 2, 1'b1, 1, "R3 short pulse");
    // R4 spacing limits
    run_case(32'hC3C3_3C3C, 8, 5, 1'b1, 1, "R4 spacing 8");
    run_case(32'h0F0F_F0F0, 12, 5, 1'b1, 1, "R4 spacing 12");
    run_case(32'hDEAD_BEEF, 7, 4, 1'b1, 1, "R4 spacing 7");
    // R10 late bit
    run_case(32'hDEAD_BEEF, 13, 5, 1'b1, 1, "R10 spacing 13");
    // R5 discrimination off
    run_case(32'h7777_1111, 20, 5, 1'b0, 1, "R5 spacing 20");
    run_case(32'h2468_ACE0, 7, 4, 1'b0, 1, "R5 spacing 7");
    // R8 early second word dropped
    disc = 1'b1;
    e0 = eos_cnt; r0 = err_cnt;
    send_word(32'h1111_2222, 10, 5, 1);
    nulls(12, 1);
    send_word(32'h3333_4444, 10, 5, 1);
    nulls(45, 1);
    chk(eos_cnt - e0 == 1, "R8 early word dropped", 32'(eos_cnt - e0), 32'd1);
    chk(last_word == 32'h1111_2222, "R8 first word kept", last_word, 32'h1111_2222);
    chk(err_cnt == r0, "R8 no err for early word", 32'(err_cnt - r0), 32'd0);
    run_case(32'h5555_AAAA, 10, 5, 1'b1, 1, "R8 after gap");
    // R2 low speed
    low_speed = 1'b1;
    nulls(45, 8);
    run_case(32'h9ABC_DEF0, 10, 5, 1'b1, 8, "R2 low speed");
    e0 = eos_cnt;
    send_word(32'h0BAD_F00D, 10, 5, 1);
    nulls(45, 8);
    chk(eos_cnt == e0, "R2 fast pattern in low speed", 32'(eos_cnt - e0), 32'd0);
    low_speed = 1'b0;
    nulls(45, 8);
    // random mix
    for (int t = 0; t < 14; t++) begin
      int per, hi;
      bit d;
      per = 6 + int'($urandom % 9);
      hi  = 2 + int'($urandom % 32'(per - 4));
      d   = bit'($urandom % 2);
      run_case($urandom, per, hi, d, 1, "R3 R4 R5 random");
    end
    chk(eos_wide == 0, "R7 eos single cycle", 32'(eos_wide), 32'd0);
    chk(both_hi == 0, "R9 eos and err exclusive", 32'(both_hi), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule